// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps track of a small pool of fixed-size packet buffer pages, one bit of an occupancy map for each page. A host writes a command byte, and the block decodes a 3-bit command from it. The commands allocate a page for transmit, reset the whole allocator, pop the receive queue, release the receive-queue head and pop, release the page named by the host's packet-number value, queue that page for transmit, or reset the transmit queue. The transmit allocation result and the number of free pages can be read back at any time. An allocation-done interrupt bit is raised when a transmit allocation succeeds.

A transmit allocation that finds no free page returns the failure code 0x80 and stays pending. Any later release retries it in the same cycle, so the host sees the interrupt without issuing the command again. The receive path can ask for a page on its own request line. It gets the lowest page still free after any transmit allocation made in that cycle. The queues themselves sit outside this block. They are driven through single-cycle pop, enqueue and reset pulses, and the block reads the receive-queue head back from them.

Top module: `pkt_page_alloc`

## Requirements
- R1: A successful transmit allocation takes the lowest-numbered free page, marks it used, and reports its number in `alloc_result` from the cycle after the command.
- R2: With every page in use, a transmit allocation writes 0x80 to `alloc_result` and changes no page's state.
- R3: A transmit allocate command (command 1) clears `alloc_irq`, and success sets it again. A failed allocation leaves it clear. A pulse on `irq_ack` also clears it.
- R4: Command 5 frees the page numbered by `pkt_num`. A `pkt_num` of NPAGES or more frees nothing.
- R5: While the last transmit result is 0x80, any release retries the allocation in the same cycle. That updates `alloc_result`, marks the page used and sets `alloc_irq`.
- R6: Commands 3 and 4 pulse `rx_pop` in the command cycle. Command 4 also frees `rx_head_page`, but only when `rx_head_valid` is high. Command 3 frees nothing.
- R7: Command 6 pulses `tx_enq` with `tx_enq_page` equal to `pkt_num`, without changing page state. Command 7 pulses `txq_reset` only.
- R8: Command 2 pulses `rxq_reset` and `txq_reset`. From the next cycle all pages are free, `alloc_result` reads 0 and no allocation is pending.
- R9: `free_count` equals the number of pages not in use.
- R10: A high `rx_req` returns, in the same cycle on `rx_page`, the lowest page left free after that cycle's transmit allocation, and marks it used. When none is left, or when command 2 is issued in the same cycle, it returns 0x80.
- R11: `mmu_busy` always reads 0.
- R12: The command is bits [7:5] of `cmd_byte`. Bits [4:0] are ignored, and command 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte written this cycle |
| cmd_byte | input | 8 | Command byte, command in bits [7:5] |
| pkt_num | input | 6 | Host packet-number value used by commands 5 and 6 |
| irq_ack | input | 1 | Clears the allocation-done interrupt |
| rx_req | input | 1 | Receive path asks for a page |
| rx_head_valid | input | 1 | Receive queue is not empty |
| rx_head_page | input | 6 | Page at the head of the receive queue |
| rx_page | output | 8 | Page granted to the receive path, or 0x80 |
| alloc_result | output | 8 | Last transmit allocation result |
| alloc_irq | output | 1 | Allocation-done interrupt bit |
| free_count | output | $clog2(NPAGES+1) | Number of free pages |
| mmu_busy | output | 1 | Busy status, always 0 |
| rx_pop | output | 1 | Pop the receive queue |
| tx_enq | output | 1 | Push a page into the transmit queue |
| tx_enq_page | output | 6 | Page to push |
| txq_reset | output | 1 | Empty the transmit queues |
| rxq_reset | output | 1 | Empty the receive queue |

## Verification
The main function is exercised in several ways:
- Filling the pool page by page in order shows that the search picks the lowest free page.
- Releasing pages out of order and then allocating shows that it picks the lowest free page rather than the next in sequence.
- Allocating into a full pool and then releasing separates a plain release from the automatic retry.
- A receive request alone is compared with one made in the same cycle as a transmit allocation, which shows which path gets a page first.
- Command bytes with junk in the low bits, and command 0, show that only the top three bits are decoded.

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc #(
  parameter int NPAGES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [7:0]                   cmd_byte,
  input  logic [5:0]                   pkt_num,
  input  logic                         irq_ack,
  input  logic                         rx_req,
  input  logic                         rx_head_valid,
  input  logic [5:0]                   rx_head_page,
  output logic [7:0]                   rx_page,
  output logic [7:0]                   alloc_result,
  output logic                         alloc_irq,
  output logic [$clog2(NPAGES+1)-1:0]  free_count,
  output logic                         mmu_busy,
  output logic                         rx_pop,
  output logic                         tx_enq,
  output logic [5:0]                   tx_enq_page,
  output logic                         txq_reset,
  output logic                         rxq_reset
);
  localparam int IW = (NPAGES > 1) ? $clog2(NPAGES) : 1;
  localparam int CW = $clog2(NPAGES + 1);
  localparam logic [6:0] NP = 7'(NPAGES);
  localparam logic [7:0] FAIL_CODE = 8'h80;

  localparam logic [2:0] C_ALLOC   = 3'd1;
  localparam logic [2:0] C_RESET   = 3'd2;
  localparam logic [2:0] C_POP     = 3'd3;
  localparam logic [2:0] C_POP_REL = 3'd4;
  localparam logic [2:0] C_RELEASE = 3'd5;
  localparam logic [2:0] C_ENQ     = 3'd6;
  localparam logic [2:0] C_TXRST   = 3'd7;

  function automatic logic [IW-1:0] lowest(input logic [NPAGES-1:0] v);
    lowest = '0;
    for (int i = NPAGES - 1; i >= 0; i--)
      if (v[i]) lowest = IW'(i);
  endfunction

  logic [NPAGES-1:0] used_q;
  logic [7:0]        result_q;
  logic              pending_q;
  logic              irq_q;

  logic [2:0] cmd;
  logic do_alloc, do_reset, do_rel_head, do_rel_num, rel_any;
  logic [IW-1:0] rel_idx, tx_idx, rx_idx;
  logic [NPAGES-1:0] rel_oh, used_rel, free0, free1, tx_oh, rx_oh;
  logic tx_try, tx_take, rx_take;

  assign cmd         = cmd_byte[7:5];
  assign do_alloc    = cmd_valid && cmd == C_ALLOC;
  assign do_reset    = cmd_valid && cmd == C_RESET;
  assign do_rel_head = cmd_valid && cmd == C_POP_REL && rx_head_valid && ({1'b0, rx_head_page} < NP);
  assign do_rel_num  = cmd_valid && cmd == C_RELEASE && ({1'b0, pkt_num} < NP);
  assign rel_any     = do_rel_head || do_rel_num;
  assign rel_idx     = do_rel_head ? rx_head_page[IW-1:0] : pkt_num[IW-1:0];

  always_comb begin
    rel_oh = '0;
    if (rel_any) rel_oh[rel_idx] = 1'b1;
  end

  assign used_rel = used_q & ~rel_oh;
  assign free0    = ~used_rel;
  assign tx_try   = do_alloc || (pending_q && rel_any);
  assign tx_idx   = lowest(free0);
  assign tx_take  = tx_try && (|free0);

  always_comb begin
    tx_oh = '0;
    if (tx_take) tx_oh[tx_idx] = 1'b1;
  end

  assign free1   = free0 & ~tx_oh;
  assign rx_idx  = lowest(free1);
  assign rx_take = rx_req && (|free1) && !do_reset;

  always_comb begin
    rx_oh = '0;
    if (rx_take) rx_oh[rx_idx] = 1'b1;
  end

  assign rx_page = rx_take ? 8'(rx_idx) : FAIL_CODE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q    <= '0;
      result_q  <= '0;
      pending_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= (irq_q && !(do_alloc || irq_ack)) || tx_take;
      if (do_reset) begin
        used_q    <= '0;
        result_q  <= '0;
        pending_q <= 1'b0;
      end else begin
        used_q <= used_rel | tx_oh | rx_oh;
        if (tx_try) begin
          result_q  <= tx_take ? 8'(tx_idx) : FAIL_CODE;
          pending_q <= !tx_take;
        end
      end
    end
  end

  always_comb begin
    free_count = '0;
    for (int i = 0; i < NPAGES; i++)
      if (!used_q[i]) free_count = free_count + CW'(1);
  end

  assign alloc_result = result_q;
  assign alloc_irq    = irq_q;
  assign mmu_busy     = 1'b0;
  assign rx_pop       = cmd_valid && (cmd == C_POP || cmd == C_POP_REL);
  assign tx_enq       = cmd_valid && cmd == C_ENQ;
  assign tx_enq_page  = pkt_num;
  assign txq_reset    = cmd_valid && (cmd == C_TXRST || cmd == C_RESET);
  assign rxq_reset    = do_reset;

  // R1
  alloc_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_alloc && !(&used_q) && !rel_any && !rx_req) |=>
      (alloc_irq && used_q[alloc_result[IW-1:0]] && $countones(used_q) == $countones($past(used_q)) + 1));

  // R2
  alloc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_alloc && (&used_q)) |=> (alloc_result == FAIL_CODE && !alloc_irq && $stable(used_q)));

  // R5
  retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && rel_any && !do_reset) |=> (alloc_result != FAIL_CODE && alloc_irq));

  // R8
  mmu_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_reset |=> (used_q == '0 && alloc_result == 8'h00));

  // R10
  rx_grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_page != FAIL_CODE) |-> (!used_q[rx_page[IW-1:0]] || rel_any));
endmodule

// File: tb/sim_pkt_page_alloc.sv
`timescale 1ns/1ps
module sim_pkt_page_alloc;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic [5:0] pkt_num = '0;
  logic irq_ack = 1'b0;
  logic rx_req = 1'b0;
  logic rx_head_valid = 1'b0;
  logic [5:0] rx_head_page = '0;
  logic [7:0] rx_page, alloc_result;
  logic alloc_irq, mmu_busy, rx_pop, tx_enq, txq_reset, rxq_reset;
  logic [$clog2(N+1)-1:0] free_count;
  logic [5:0] tx_enq_page;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pkt_page_alloc #(.NPAGES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .pkt_num(pkt_num), .irq_ack(irq_ack), .rx_req(rx_req),
    .rx_head_valid(rx_head_valid), .rx_head_page(rx_head_page),
    .rx_page(rx_page), .alloc_result(alloc_result), .alloc_irq(alloc_irq),
    .free_count(free_count), .mmu_busy(mmu_busy), .rx_pop(rx_pop),
    .tx_enq(tx_enq), .tx_enq_page(tx_enq_page), .txq_reset(txq_reset),
    .rxq_reset(rxq_reset));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] b, input logic [5:0] pn);
    cmd_valid = 1'b1; cmd_byte = b; pkt_num = pn;
    #1;
  endtask

  task automatic finish_cycle();
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; rx_req = 1'b0; irq_ack = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    check("R9 reset free", free_count, 4);
    check("R1 reset result", alloc_result, 0);
    check("R3 reset irq", alloc_irq, 0);
    check("R11 busy", mmu_busy, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < N; i++) begin
      issue(8'h20, 0); finish_cycle();
      check("R1 fill result", alloc_result, i);
      check("R3 fill irq", alloc_irq, 1);
      check("R9 fill free", free_count, N - 1 - i);
    end
    issue(8'h20, 0); finish_cycle();
    check("R2 full result", alloc_result, 'h80);
    check("R3 irq cleared on fail", alloc_irq, 0);
    check("R2 full free", free_count, 0);
  endtask

  task automatic t_retry();
    issue(8'hA0, 2); finish_cycle();
    check("R5 retry result", alloc_result, 2);
    check("R5 retry irq", alloc_irq, 1);
    check("R5 retry free", free_count, 0);
  endtask

  task automatic t_release();
    issue(8'hA0, 1); finish_cycle();
    check("R4 release free", free_count, 1);
    check("R4 result held", alloc_result, 2);
    issue(8'hA0, 9); finish_cycle();
    check("R4 out of range", free_count, 1);
    issue(8'h20, 0); finish_cycle();
    check("R1 lowest after release", alloc_result, 1);
    check("R9 free", free_count, 0);
    irq_ack = 1'b1; finish_cycle();
    check("R3 ack", alloc_irq, 0);
    issue(8'hA0, 0); finish_cycle();
    issue(8'hA0, 3); finish_cycle();
    check("R9 two freed", free_count, 2);
  endtask

  task automatic t_rx();
    rx_req = 1'b1; #1;
    check("R10 rx grant", rx_page, 0);
    finish_cycle();
    check("R10 rx used", free_count, 1);
    rx_req = 1'b1; issue(8'h20, 0);
    check("R10 tx first", rx_page, 'h80);
    finish_cycle();
    check("R10 tx got page", alloc_result, 3);
    check("R9 full", free_count, 0);
    rx_req = 1'b1; #1;
    check("R10 none free", rx_page, 'h80);
    finish_cycle();
  endtask

  task automatic t_pop();
    rx_head_valid = 1'b1; rx_head_page = 1;
    issue(8'h80, 0);
    check("R6 pop on cmd4", rx_pop, 1);
    finish_cycle();
    check("R6 head released", free_count, 1);
    rx_head_valid = 1'b0;
    issue(8'h80, 0);
    check("R6 pop empty", rx_pop, 1);
    finish_cycle();
    check("R6 empty no release", free_count, 1);
    rx_head_valid = 1'b1; rx_head_page = 2;
    issue(8'h60, 0);
    check("R6 pop cmd3", rx_pop, 1);
    finish_cycle();
    check("R6 cmd3 no release", free_count, 1);
    rx_head_valid = 1'b0;
  endtask

  task automatic t_txq();
    issue(8'hC0, 2);
    check("R7 enq", tx_enq, 1);
    check("R7 enq page", tx_enq_page, 2);
    check("R7 enq no reset", txq_reset, 0);
    finish_cycle();
    check("R7 enq free", free_count, 1);
    issue(8'hE0, 0);
    check("R7 tx reset", txq_reset, 1);
    check("R7 rx untouched", rxq_reset, 0);
    finish_cycle();
  endtask

  task automatic t_field();
    issue(8'h3F, 0); finish_cycle();
    check("R12 low bits ignored", alloc_result, 1);
    check("R12 free", free_count, 0);
    issue(8'h1F, 5);
    check("R12 cmd0 pop", rx_pop, 0);
    check("R12 cmd0 enq", tx_enq, 0);
    finish_cycle();
    check("R12 cmd0 free", free_count, 0);
    check("R12 cmd0 result", alloc_result, 1);
  endtask

  task automatic t_mmu_reset();
    rx_req = 1'b1; issue(8'h40, 0);
    check("R8 rxq reset", rxq_reset, 1);
    check("R8 txq reset", txq_reset, 1);
    check("R10 refused on reset", rx_page, 'h80);
    finish_cycle();
    check("R8 all free", free_count, 4);
    check("R8 result", alloc_result, 0);
    issue(8'hA0, 1); finish_cycle();
    check("R8 no pending", alloc_result, 0);
    check("R11 busy", mmu_busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_fill();
    t_retry();
    t_release();
    t_rx();
    t_pop();
    t_txq();
    t_field();
    t_mmu_reset();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule